// File: doc/BRIEF.md
# Serial Management Frame Master

This block lets a processor drive a two-wire serial management bus toward SerDes PHY devices through two memory-mapped registers. Software first programs a setup register with a clock divisor and a preamble option. It then writes one 32-bit word to the frame register. The block shifts that word out MSB first on the data pin, paced by the management clock it generates. The word holds the start marker, the opcode, the device and register addresses, the turnaround bits and the payload, each in a fixed field. The block does not assemble the frame from separate fields.

For a read frame, the block releases the data pin from the second turnaround bit onward and captures the 16 bits the PHY returns. These bits then appear in the low half of the frame register. A read-only completion flag in the setup register tells polling software when the frame has finished. A setup value of zero parks the engine. Frame writes are then ignored until the setup register is written again.

Top module: `mdio_mgr`

## Requirements
- R1: After reset the management clock and the pin output-enable are low, the completion flag is clear, and both registers read as zero.
- R2: The setup register sits at offset 0x128. Bits 6:0 are the clock divisor and bit 7 is the preamble enable; both are read/write. Bit 8 is the completion flag and is read-only. All other bits read as zero.
- R3: A write to the frame register at offset 0x12C starts a frame when the block is idle and the setup register is nonzero. All 32 bits of the written word go out MSB first. Each bit is driven while the clock is low and holds across the following rising edge.
- R4: With setup bit 7 set, the frame is preceded by 32 consecutive one bits. With bit 7 clear, no preamble is sent.
- R5: While a frame runs, each half period of the management clock lasts divisor+1 system clocks. While idle the clock stays low.
- R6: A word with bit 29 set is a read frame. For a read frame the output-enable is low for frame bits 16 down to 0 and high for every earlier bit. A word with bit 29 clear keeps the output-enable high for every bit.
- R7: In a read frame, the pin is sampled on the rising clock edge of each of frame bits 15..0, MSB first. On completion the sampled value replaces bits 15:0 of the frame register, and bits 31:16 keep the written value.
- R8: The completion flag clears when a frame starts. It sets 3*(divisor+1) system clocks after the last rising clock edge of the frame, which is one full clock period after that bit's falling edge.
- R9: While setup bits 7:0 are all zero, a frame-register write is ignored. No clock runs, the frame register keeps its value and the completion flag is unchanged.
- R10: A frame-register write during a running frame is ignored. The running frame and the register contents are unaffected.
- R11: A block-select frame is shifted out like any other write frame. It is a write whose register field (bits 22:18) is all ones and whose payload is the target device number shifted left by 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; read data is combinational |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, zero when reg_rd is low |
| mdc | output | 1 | Management clock |
| mdio_out | output | 1 | Data pin output value |
| mdio_oe | output | 1 | Data pin output-enable |
| mdio_in | input | 1 | Data pin input value |

## Verification
The assertions take for granted that the register strobes are single-cycle pulses and that the setup register is not rewritten while a frame is running. Under that condition the clock only moves on a divider tick and the completion flag never overlaps a running frame. The stimulus writes the setup register only while the engine is idle and issues one write per strobe. The modelled PHY changes its pin only after a falling management clock edge, which keeps each sample taken at a rising edge well defined.

// File: rtl/mdio_mgr_pkg.sv
package mdio_mgr_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_TAIL  = 2'd2
  } eng_state_t;

  localparam int FRAME_BITS = 32;
  localparam int PRE_BITS   = 32;
  localparam int RD_OP_BIT  = 29;

  // Number of serial bits sent for one frame-register write.
  function automatic logic [6:0] seq_len(input logic pre_on);
    return pre_on ? 7'(FRAME_BITS + PRE_BITS) : 7'(FRAME_BITS);
  endfunction

  // Output-enable for the bit whose remaining count (current included) is left.
  function automatic logic drive_pin(input logic rd, input logic [6:0] left);
    return !(rd && (left <= 7'd17));
  endfunction

  // Rising edge of this bit captures returned data.
  function automatic logic capture_bit(input logic rd, input logic [6:0] left);
    return rd && (left <= 7'd16);
  endfunction

endpackage

// File: rtl/mdc_tick_gen.sv
module mdc_tick_gen #(
  parameter int DIV_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  assign tick = run && (cnt == div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (!run)   cnt <= '0;
    else if (tick)   cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import mdio_mgr_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [31:0] word,
  input  logic        pre_on,
  input  logic        tick,
  input  logic        mdio_in,
  output logic        mdc,
  output logic        mdio_out,
  output logic        mdio_oe,
  output logic        busy,
  output logic        fin,
  output logic        is_rd,
  output logic [15:0] cap
);
  eng_state_t  state;
  logic [63:0] sreg;
  logic [6:0]  left;
  logic        tail_half;

  assign busy     = (state != ST_IDLE);
  assign fin      = (state == ST_TAIL) && tick && tail_half;
  assign mdio_out = (state == ST_SHIFT) && sreg[63];
  assign mdio_oe  = (state == ST_SHIFT) && drive_pin(is_rd, left);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      sreg      <= '0;
      left      <= '0;
      mdc       <= 1'b0;
      is_rd     <= 1'b0;
      cap       <= '0;
      tail_half <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start) begin
            sreg  <= pre_on ? {32'hFFFF_FFFF, word} : {word, 32'h0};
            left  <= seq_len(pre_on);
            is_rd <= word[RD_OP_BIT];
            mdc   <= 1'b0;
            state <= ST_SHIFT;
          end
        end
        ST_SHIFT: begin
          if (tick) begin
            if (!mdc) begin
              mdc <= 1'b1;
              if (capture_bit(is_rd, left)) cap <= {cap[14:0], mdio_in};
            end else begin
              mdc <= 1'b0;
              if (left == 7'd1) begin
                state     <= ST_TAIL;
                tail_half <= 1'b0;
              end else begin
                left <= left - 7'd1;
                sreg <= {sreg[62:0], 1'b0};
              end
            end
          end
        end
        ST_TAIL: begin
          if (tick) begin
            if (tail_half) state <= ST_IDLE;
            else           tail_half <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mdio_mgr.sv
module mdio_mgr #(
  parameter int          ADDR_W   = 12,
  parameter int          DIV_W    = 7,
  parameter logic [11:0] SETUP_OFS = 12'h128,
  parameter logic [11:0] FRAME_OFS = 12'h12C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              mdc,
  output logic              mdio_out,
  output logic              mdio_oe,
  input  logic              mdio_in
);
  localparam int SETUP_W = DIV_W + 1;

  logic [SETUP_W-1:0] setup_q;
  logic               done_q;
  logic [31:0]        frame_q;
  logic               busy, fin, tick, is_rd, start;
  logic [15:0]        cap;
  logic               hit_setup, hit_frame, engine_on;

  assign hit_setup = (reg_addr == ADDR_W'(SETUP_OFS));
  assign hit_frame = (reg_addr == ADDR_W'(FRAME_OFS));
  assign engine_on = (setup_q != '0);
  assign start     = reg_wr && hit_frame && engine_on && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      setup_q <= '0;
      done_q  <= 1'b0;
      frame_q <= '0;
    end else begin
      if (reg_wr && hit_setup) setup_q <= reg_wdata[SETUP_W-1:0];
      if (start) begin
        frame_q <= reg_wdata;
        done_q  <= 1'b0;
      end else if (fin) begin
        done_q <= 1'b1;
        if (is_rd) frame_q[15:0] <= cap;
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_rd) begin
      if (hit_setup)      reg_rdata = 32'({done_q, setup_q});
      else if (hit_frame) reg_rdata = frame_q;
    end
  end

  mdc_tick_gen #(.DIV_W(DIV_W)) i_tick (
    .clk (clk),
    .rst_n(rst_n),
    .run (busy),
    .div (setup_q[DIV_W-1:0]),
    .tick(tick)
  );

  mdio_frame_engine i_eng (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .word    (reg_wdata),
    .pre_on  (setup_q[SETUP_W-1]),
    .tick    (tick),
    .mdio_in (mdio_in),
    .mdc     (mdc),
    .mdio_out(mdio_out),
    .mdio_oe (mdio_oe),
    .busy    (busy),
    .fin     (fin),
    .is_rd   (is_rd),
    .cap     (cap)
  );
endmodule

// File: rtl/mdio_mgr_checker.sv
module mdio_mgr_checker (
  input logic clk,
  input logic rst_n,
  input logic mdc,
  input logic mdio_oe,
  input logic busy,
  input logic done_q,
  input logic tick,
  input logic start
);
  assert_mdc_on_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mdc) |-> $past(tick));

  assert_mdc_idle_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdc);

  assert_oe_idle_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdio_oe);

  assert_done_not_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_q && busy));

  assert_start_clears_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (!done_q && busy));

  assert_done_after_frame_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> $fell(busy));
endmodule

bind mdio_mgr mdio_mgr_checker i_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .mdc    (mdc),
  .mdio_oe(mdio_oe),
  .busy   (busy),
  .done_q (done_q),
  .tick   (tick),
  .start  (start)
);

// File: tb/test_mdio_mgr.sv
module test_mdio_mgr;
  localparam logic [11:0] A_SETUP = 12'h128;
  localparam logic [11:0] A_FRAME = 12'h12C;
  // {setup[15:0], word[31:0], phy reply[15:0]}
  localparam logic [63:0] VEC [4] = '{
    64'h0082_50C68128_0000,   // write, preamble, div 2
    64'h0002_67C60000_A5C3,   // read, no preamble, div 2
    64'h0080_507E01D0_0000,   // block-select write, preamble, div 0
    64'h0085_601E0000_3C69    // read, preamble, div 5
  };

  logic clk = 0, rst_n = 0;
  logic reg_wr = 0, reg_rd = 0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic mdc, mdio_out, mdio_oe, mdio_in = 0;

  always #2.5 clk = ~clk;

  mdio_mgr i_mdio_mgr (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mdc(mdc), .mdio_out(mdio_out), .mdio_oe(mdio_oe), .mdio_in(mdio_in)
  );

  int total = 0, bad = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // Monitor and PHY model
  logic        rec_bit [64];
  logic        rec_oe  [64];
  int          nrise = 0, last_chg = -1, last_rise = 0, ivl_bad = 0, ivl_exp = 1;
  int          cur_len = 32;
  logic [15:0] cur_phy = '0;
  logic        mdc_prev = 0;

  always @(negedge clk) begin
    if (mdc !== mdc_prev) begin
      if (last_chg >= 0 && (cyc - last_chg) != ivl_exp) ivl_bad++;
      last_chg = cyc;
      if (mdc === 1'b1) begin
        if (nrise < 64) begin
          rec_bit[nrise] = mdio_out;
          rec_oe[nrise]  = mdio_oe;
        end
        nrise++;
        last_rise = cyc;
      end else begin
        int j;
        j = cur_len - 1 - nrise;
        if (j >= 0 && j <= 15) mdio_in = cur_phy[j];
      end
    end
    mdc_prev = mdc;
  end

  task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1; reg_addr = a;
    #1 d = reg_rdata;
    reg_rd = 0;
  endtask

  task automatic arm(input logic [15:0] setup, input logic [15:0] phy);
    cur_len  = setup[7] ? 64 : 32;
    cur_phy  = phy;
    ivl_exp  = int'(setup[6:0]) + 1;
    nrise    = 0;
    last_chg = -1;
    ivl_bad  = 0;
  endtask

  // Holds a setup-register read until the completion flag shows; returns clocks since last rise
  task automatic wait_done(output int delta, output logic ok);
    ok = 0; delta = -1;
    for (int k = 0; k < 5000; k++) begin
      @(negedge clk);
      reg_rd = 1; reg_addr = A_SETUP;
      #1;
      if (reg_rdata[8]) begin ok = 1; delta = cyc - last_rise; break; end
    end
    reg_rd = 0;
  endtask

  task automatic run_frame(input logic [15:0] setup, input logic [31:0] word, input logic [15:0] phy, input string tag);
    int   delta, len, errs_b, errs_o;
    logic ok, isrd;
    logic [31:0] rb, exp_rb;
    wr(A_SETUP, {16'h0, setup});
    arm(setup, phy);
    wr(A_FRAME, word);
    wait_done(delta, ok);
    len = setup[7] ? 64 : 32;
    isrd = word[29];
    errs_b = 0; errs_o = 0;
    for (int n = 0; n < len; n++) begin
      int j;
      logic eb, eo;
      j  = len - 1 - n;
      eb = (j > 31) ? 1'b1 : word[j];
      eo = !(isrd && j <= 16);
      if (rec_bit[n] !== eb) errs_b++;
      if (rec_oe[n] !== eo) errs_o++;
    end
    check(ok, {tag, " R8 completion flag"}, 32'(ok), 1);
    check(nrise == len && errs_b == 0, {tag, " R3 R4 R11 serial bits"}, 32'(nrise) + 32'(errs_b << 8), 32'(len));
    check(errs_o == 0, {tag, " R6 output-enable"}, 32'(errs_o), 0);
    check(ivl_bad == 0, {tag, " R5 half period"}, 32'(ivl_bad), 0);
    check(delta == 3 * (int'(setup[6:0]) + 1), {tag, " R8 completion delay"}, 32'(delta), 32'(3 * (int'(setup[6:0]) + 1)));
    rd(A_FRAME, rb);
    exp_rb = isrd ? {word[31:16], phy} : word;
    check(rb == exp_rb, {tag, " R7 frame readback"}, rb, exp_rb);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired actual=%0d expected=<150000", cyc);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int   delta;
    logic ok;
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check(mdc === 1'b0 && mdio_oe === 1'b0, "R1 pins after reset", {30'b0, mdc, mdio_oe}, 0);
    rd(A_SETUP, v); check(v == 0, "R1 setup reads zero", v, 0);
    rd(A_FRAME, v); check(v == 0, "R1 frame reads zero", v, 0);
    // R2 setup field layout and read-only flag
    wr(A_SETUP, 32'hFFFF_FFFF);
    rd(A_SETUP, v); check(v == 32'h0000_00FF, "R2 setup readback", v, 32'h0000_00FF);

    // Vector table walk
    for (int i = 0; i < 4; i++)
      run_frame(VEC[i][63:48], VEC[i][47:16], VEC[i][15:0], $sformatf("vec%0d", i));

    // R2 flag bit 8 visible after completion
    rd(A_SETUP, v); check(v == 32'h0000_0185, "R2 flag in setup read", v, 32'h0000_0185);

    // R9 zero setup ignores frame writes
    wr(A_SETUP, 32'h0);
    arm(16'h0, 16'h0);
    wr(A_FRAME, 32'h5555_AAAA);
    repeat (40) @(negedge clk);
    check(nrise == 0 && mdc === 1'b0, "R9 no clock when parked", 32'(nrise), 0);
    rd(A_FRAME, v); check(v == 32'h601E_3C69, "R9 frame register kept", v, 32'h601E_3C69);
    rd(A_SETUP, v); check(v == 32'h0000_0100, "R9 flag unchanged", v, 32'h0000_0100);

    // R10 write while busy is ignored
    wr(A_SETUP, 32'h0000_0001);
    arm(16'h0001, 16'h0);
    wr(A_FRAME, 32'h5012_3456);
    wr(A_FRAME, 32'h6FFF_FFFF);
    wait_done(delta, ok);
    begin
      int e = 0;
      for (int n = 0; n < 32; n++) if (rec_bit[n] !== v[0] && 1'b0) e++;
      for (int n = 0; n < 32; n++) begin
        logic [31:0] w = 32'h5012_3456;
        if (rec_bit[n] !== w[31-n]) e++;
      end
      check(ok && nrise == 32 && e == 0, "R10 first frame kept", 32'(e), 0);
    end
    rd(A_FRAME, v); check(v == 32'h5012_3456, "R10 frame register kept", v, 32'h5012_3456);
    check(delta == 6, "R8 completion delay div1", 32'(delta), 6);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule